// File: doc/BRIEF.md
# Split Dual 8-bit Auto-Reload Timer

This block holds two independent 8-bit up-counters, a high half and a low half. Each half has its own reload register and its own sticky overflow flag. When a half rolls over past 0xFF it loads its reload value at once, so the period of a half is set by how far its reload value sits below the top of the range. The two halves differ in how they are gated. The high half counts only while its run input is set. The low half counts all the time, and its overflow reaches the interrupt line only when a separate enable is set.

Each half takes its count ticks from one of three sources. A per-half select bit, when set, gives one tick for every system clock cycle. When that bit is clear, a shared external-select bit chooses between two prescaled sources. One is the system clock divided by 12, taken from a free-running modulo-12 counter. The other is an external clock input, which passes through a two-flop synchronizer and a divide-by-8 counter of its rising edges. There is no streaming data path. All pins are plain control and status levels, plus single-cycle write strobes.

Top module: `split_reload_timer`

## Requirements
- R1: Each half is an 8-bit counter that rises by exactly one on each of its own ticks. It does not change on cycles without a tick, and it does not depend on the other half.
- R2: The high half advances only while `run_hi_i` is 1. The low half has no run gate.
- R3: When a half's `sel_sys_*_i` is 1, that half gets a tick every system clock cycle, whatever value `ext_sel_i` holds.
- R4: When a half's `sel_sys_*_i` is 0 and `ext_sel_i` is 0, that half gets exactly one tick every 12 system clock cycles.
- R5: When a half's `sel_sys_*_i` is 0 and `ext_sel_i` is 1, that half gets one tick for every 8 rising edges of `ext_clk_i`, seen after a two-flop synchronizer.
- R6: A tick that arrives while a half holds 0xFF loads that half's reload value in the same cycle, without passing through 0x00, and sets that half's flag.
- R7: A write strobe (`rld_we_hi_i` or `rld_we_lo_i`) stores `rld_data_i` as that half's reload value. It leaves the current count untouched. An overflow in the same cycle as the write uses the old reload value.
- R8: A flag is never cleared by hardware. It falls in the cycle after a clear strobe for its half.
- R9: If a clear strobe and an overflow of the same half fall in the same cycle, the flag stays set.
- R10: `irq_o` is the combinational level `irq_en_i & (flag_hi_o | (lo_irq_en_i & flag_lo_o))`.
- R11: While `rst_ni` is low, both counts, both reload values, both flags and `irq_o` are 0, and both prescalers restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_clk_i | input | 1 | External clock, asynchronous to clk_i |
| run_hi_i | input | 1 | Run gate for the high half |
| sel_sys_hi_i | input | 1 | High half ticks every system cycle when 1 |
| sel_sys_lo_i | input | 1 | Low half ticks every system cycle when 1 |
| ext_sel_i | input | 1 | Shared prescaled source: 0 system/12, 1 external/8 |
| irq_en_i | input | 1 | Master interrupt enable |
| lo_irq_en_i | input | 1 | Lets low-half overflows reach irq_o |
| rld_data_i | input | 8 | Reload value to store |
| rld_we_hi_i | input | 1 | Store rld_data_i as the high reload value |
| rld_we_lo_i | input | 1 | Store rld_data_i as the low reload value |
| clr_hi_i | input | 1 | Clear the high flag |
| clr_lo_i | input | 1 | Clear the low flag |
| cnt_hi_o | output | 8 | High half count |
| cnt_lo_o | output | 8 | Low half count |
| flag_hi_o | output | 1 | High half overflow flag |
| flag_lo_o | output | 1 | Low half overflow flag |
| irq_o | output | 1 | Combined interrupt request level |

## Verification
The bench sweeps all 256 reload values with per-cycle ticks. Along the way it toggles the run gate, the external-select bit and the low interrupt enable. This catches three kinds of fault: a half that passes through 0x00 or reloads from the wrong register, a run gate that also stalls the low half, and an external-select bit that still matters when the per-half select is set. A dedicated sequence lands a flag clear on a non-overflow cycle and then on an overflow cycle. A design where the clear beats the set drops the flag there, and one that clears flags on its own loses them during the sweep. The two prescaled sources are checked by measuring the spacing between count steps. An off-by-one modulo counter shows up as 11 or 13 cycles instead of 12. An edge counter that counts levels or both edges shows up as a wrong 64-cycle external period.

// File: rtl/sptmr_pkg.sv
package sptmr_pkg;

  // Which tick enable feeds a counter half.
  typedef enum logic [1:0] {
    SRC_SYS = 2'd0,
    SRC_DIV = 2'd1,
    SRC_EXT = 2'd2
  } tick_src_e;

  // Two-level choice: the per-half select wins; otherwise the shared bit decides.
  function automatic tick_src_e pick_src(input logic sel_sys, input logic ext_sel);
    if (sel_sys)      return SRC_SYS;
    else if (ext_sel) return SRC_EXT;
    else              return SRC_DIV;
  endfunction

  localparam int unsigned HALVES = 2;
  localparam int unsigned LO_IDX = 0;
  localparam int unsigned HI_IDX = 1;

endpackage

// File: rtl/sptmr_prescale.sv
module sptmr_prescale #(
  parameter int unsigned SYS_DIV     = 12,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  output logic tick_div_o,
  output logic tick_ext_o
);
  localparam int unsigned SW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam int unsigned EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [SW-1:0] SYS_LAST = SW'(SYS_DIV - 1);
  localparam logic [EW-1:0] EXT_LAST = EW'(EXT_DIV - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   ext_rise;
  logic [SW-1:0]          sys_cnt_q;
  logic [EW-1:0]          ext_cnt_q;

  // Synchronizer chain followed by one more flop for edge detection.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~last_q;

  // Free-running modulo counter for the system-clock divider.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                   sys_cnt_q <= '0;
    else if (sys_cnt_q == SYS_LAST) sys_cnt_q <= '0;
    else                           sys_cnt_q <= sys_cnt_q + 1'b1;
  end

  // Counter of synchronized rising edges.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) ext_cnt_q <= '0;
    else if (ext_rise) begin
      if (ext_cnt_q == EXT_LAST) ext_cnt_q <= '0;
      else                       ext_cnt_q <= ext_cnt_q + 1'b1;
    end
  end

  assign tick_div_o = (sys_cnt_q == SYS_LAST);
  assign tick_ext_o = ext_rise && (ext_cnt_q == EXT_LAST);

  // R4: the divided tick is a lone single-cycle pulse.
  p_div_tick_lone_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_div_o |=> !tick_div_o);

  // R4: the divider counter never leaves its range.
  p_div_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_cnt_q <= SYS_LAST);

  // R5: an external tick needs a fresh rising edge, so two never touch.
  p_ext_tick_lone_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_ext_o |=> !tick_ext_o);

  // R5: the edge counter only moves on a detected rise.
  p_ext_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rise |=> $stable(ext_cnt_q));

endmodule

// File: rtl/sptmr_half.sv
module sptmr_half
  import sptmr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         sel_sys_i,
  input  logic         ext_sel_i,
  input  logic         tick_div_i,
  input  logic         tick_ext_i,
  input  logic         rld_we_i,
  input  logic [W-1:0] rld_data_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);
  localparam logic [W-1:0] TOP = '1;

  tick_src_e    src;
  logic         raw_tick;
  logic         tick;
  logic         wrap;
  logic [W-1:0] cnt_q;
  logic [W-1:0] rld_q;
  logic         flag_q;

  assign src = pick_src(sel_sys_i, ext_sel_i);

  always_comb begin
    unique case (src)
      SRC_SYS: raw_tick = 1'b1;
      SRC_EXT: raw_tick = tick_ext_i;
      default: raw_tick = tick_div_i;
    endcase
  end

  assign tick = raw_tick & run_i;
  assign wrap = tick && (cnt_q == TOP);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wrap) cnt_q <= rld_q;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       rld_q <= '0;
    else if (rld_we_i) rld_q <= rld_data_i;
  end

  // Set has priority over clear.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (wrap)   flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R1: without a tick the count holds.
  p_hold_no_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_q));

  // R1: a tick below the top steps by one.
  p_step_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_q != TOP) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R6: rolling over loads the reload value that was held before the edge.
  p_reload_on_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> cnt_q == $past(rld_q));

  // R9: an overflow leaves the flag set, clear or not.
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_q);

  // R8: the flag stays up until a clear strobe.
  p_flag_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);

  // R7: a reload write does not disturb the count by itself.
  p_write_keeps_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_we_i && !tick) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
  import sptmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYS_DIV     = 12,
  parameter int unsigned EXT_DIV     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             run_hi_i,
  input  logic             sel_sys_hi_i,
  input  logic             sel_sys_lo_i,
  input  logic             ext_sel_i,
  input  logic             irq_en_i,
  input  logic             lo_irq_en_i,
  input  logic [CNT_W-1:0] rld_data_i,
  input  logic             rld_we_hi_i,
  input  logic             rld_we_lo_i,
  input  logic             clr_hi_i,
  input  logic             clr_lo_i,
  output logic [CNT_W-1:0] cnt_hi_o,
  output logic [CNT_W-1:0] cnt_lo_o,
  output logic             flag_hi_o,
  output logic             flag_lo_o,
  output logic             irq_o
);
  logic                tick_div;
  logic                tick_ext;
  logic [HALVES-1:0]   run_v;
  logic [HALVES-1:0]   sel_v;
  logic [HALVES-1:0]   we_v;
  logic [HALVES-1:0]   clr_v;
  logic [HALVES-1:0]   flag_v;
  logic [CNT_W-1:0]    cnt_v [HALVES];

  sptmr_prescale #(
    .SYS_DIV    (SYS_DIV),
    .EXT_DIV    (EXT_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) prescale_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_clk_i (ext_clk_i),
    .tick_div_o(tick_div),
    .tick_ext_o(tick_ext)
  );

  assign sel_v[HI_IDX] = sel_sys_hi_i;
  assign sel_v[LO_IDX] = sel_sys_lo_i;
  assign we_v[HI_IDX]  = rld_we_hi_i;
  assign we_v[LO_IDX]  = rld_we_lo_i;
  assign clr_v[HI_IDX] = clr_hi_i;
  assign clr_v[LO_IDX] = clr_lo_i;

  for (genvar g = 0; g < HALVES; g++) begin : g_half
    // Only the high half carries a run gate; the low half is always enabled.
    if (g == HI_IDX) begin : g_gated
      assign run_v[g] = run_hi_i;
    end else begin : g_free
      assign run_v[g] = 1'b1;
    end

    sptmr_half #(.W(CNT_W)) half_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run_v[g]),
      .sel_sys_i (sel_v[g]),
      .ext_sel_i (ext_sel_i),
      .tick_div_i(tick_div),
      .tick_ext_i(tick_ext),
      .rld_we_i  (we_v[g]),
      .rld_data_i(rld_data_i),
      .clr_i     (clr_v[g]),
      .cnt_o     (cnt_v[g]),
      .flag_o    (flag_v[g])
    );
  end

  assign cnt_hi_o  = cnt_v[HI_IDX];
  assign cnt_lo_o  = cnt_v[LO_IDX];
  assign flag_hi_o = flag_v[HI_IDX];
  assign flag_lo_o = flag_v[LO_IDX];
  assign irq_o     = irq_en_i & (flag_v[HI_IDX] | (lo_irq_en_i & flag_v[LO_IDX]));

  // R2: a stopped high half keeps its count.
  p_run_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_hi_i |=> cnt_hi_o == $past(cnt_hi_o));

  // R3: the per-cycle source moves the low half every cycle below the top.
  p_sys_every_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_sys_lo_i && cnt_lo_o != '1) |=> cnt_lo_o == $past(cnt_lo_o) + 1'b1);

  // R10: a set high flag with interrupts on always requests.
  p_irq_hi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && flag_hi_o) |-> irq_o);

  // R10: a low flag alone is masked without its own enable.
  p_irq_lo_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_irq_en_i && !flag_hi_o) |-> !irq_o);

  // R11: the outputs are quiet in the first cycle after reset.
  p_reset_quiet_r11: assert property (@(posedge clk_i)
    !rst_ni |=> (flag_hi_o == 1'b0 && flag_lo_o == 1'b0 && cnt_hi_o == '0));

endmodule

// File: tb/split_reload_timer_tb.sv
`timescale 1ns/1ps
module split_reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       run_hi = 1'b0, sel_hi = 1'b0, sel_lo = 1'b0, ext_sel = 1'b0;
  logic       irq_en = 1'b0, lo_en = 1'b0;
  logic [7:0] rld_data = 8'h00;
  logic       we_hi = 1'b0, we_lo = 1'b0, clr_hi = 1'b0, clr_lo = 1'b0;
  logic [7:0] cnt_hi, cnt_lo;
  logic       flag_hi, flag_lo, irq;

  int  total = 0;
  int  bad = 0;
  bit  track = 1'b0;
  bit  ext_on = 1'b0;
  logic [7:0] m_hi, m_lo, m_rhi, m_rlo;
  logic       m_fhi, m_flo;

  always #2 clk = ~clk;

  split_reload_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_clk_i(ext_clk), .run_hi_i(run_hi),
    .sel_sys_hi_i(sel_hi), .sel_sys_lo_i(sel_lo), .ext_sel_i(ext_sel),
    .irq_en_i(irq_en), .lo_irq_en_i(lo_en), .rld_data_i(rld_data),
    .rld_we_hi_i(we_hi), .rld_we_lo_i(we_lo), .clr_hi_i(clr_hi), .clr_lo_i(clr_lo),
    .cnt_hi_o(cnt_hi), .cnt_lo_o(cnt_lo), .flag_hi_o(flag_hi), .flag_lo_o(flag_lo),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model for per-cycle sources, written from the requirements.
  task automatic model_edge();
    bit tk_hi, tk_lo, wr_hi, wr_lo;
    tk_hi = sel_hi && run_hi;
    tk_lo = sel_lo;
    wr_hi = tk_hi && (m_hi == 8'hFF);
    wr_lo = tk_lo && (m_lo == 8'hFF);
    if (wr_hi) m_hi = m_rhi; else if (tk_hi) m_hi = m_hi + 8'd1;
    if (wr_lo) m_lo = m_rlo; else if (tk_lo) m_lo = m_lo + 8'd1;
    if (wr_hi) m_fhi = 1'b1; else if (clr_hi) m_fhi = 1'b0;
    if (wr_lo) m_flo = 1'b1; else if (clr_lo) m_flo = 1'b0;
    if (we_hi) m_rhi = rld_data;
    if (we_lo) m_rlo = rld_data;
  endtask

  task automatic step();
    logic m_irq;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (track) begin
      m_irq = irq_en & (m_fhi | (lo_en & m_flo));
      chk(cnt_lo === m_lo, "R1/R6/R7 cnt_lo", cnt_lo, m_lo);
      chk(cnt_hi === m_hi, "R2/R3 cnt_hi", cnt_hi, m_hi);
      chk(flag_lo === m_flo, "R6/R8 flag_lo", flag_lo, m_flo);
      chk(flag_hi === m_fhi, "R6/R8 flag_hi", flag_hi, m_fhi);
      chk(irq === m_irq, "R10 irq", irq, m_irq);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {run_hi, sel_hi, sel_lo, ext_sel, irq_en, lo_en} = '0;
    {we_hi, we_lo, clr_hi, clr_lo} = '0;
    rld_data = 8'h00;
    ext_on = 1'b0;
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
    chk(cnt_hi === 8'h00 && cnt_lo === 8'h00, "R11 counts", {cnt_hi, cnt_lo}, 0);
    chk(flag_hi === 1'b0 && flag_lo === 1'b0 && irq === 1'b0, "R11 flags",
        {flag_hi, flag_lo, irq}, 0);
    m_hi = 0; m_lo = 0; m_rhi = 0; m_rlo = 0; m_fhi = 0; m_flo = 0;
    rst_n = 1'b1;
  endtask

  // Measures the spacing of low-half steps; both halves share the source.
  task automatic spacing(input int exp_gap, input string tag, input int reps);
    logic [7:0] prev;
    int gap;
    prev = cnt_lo;
    for (int w = 0; w < 400 && cnt_lo == prev; w++) step();
    for (int k = 0; k < reps; k++) begin
      prev = cnt_lo;
      gap = 0;
      while (cnt_lo == prev && gap < 400) begin
        step();
        gap++;
      end
      chk(gap == exp_gap, tag, gap, exp_gap);
      chk(cnt_lo == prev + 8'd1, {tag, " step"}, cnt_lo, prev + 8'd1);
      chk(cnt_hi == cnt_lo, "R1 halves share prescaled source", cnt_hi, cnt_lo);
    end
  endtask

  // External clock: toggles every 4 system cycles, one rise per 8 cycles.
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      if (ext_on) begin
        ph++;
        if (ph == 4) begin
          ph = 0;
          ext_clk = ~ext_clk;
        end
      end
    end
  end

  initial begin
    #700000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // Sweep every reload value with per-cycle ticks.
    track = 1'b1;
    sel_hi = 1'b1; sel_lo = 1'b1; irq_en = 1'b1;
    for (int r = 0; r < 256; r++) begin
      rld_data = 8'(r);        we_lo = 1'b1; step(); we_lo = 1'b0;
      rld_data = 8'(255 - r);  we_hi = 1'b1; step(); we_hi = 1'b0;
      run_hi  = (r % 3) != 0;  // R2
      lo_en   = r[1];          // R10
      ext_sel = r[2];          // R3
      for (int c = 0; c < (256 - r) + 3; c++) step();
      if (r % 4 == 0) begin
        clr_hi = 1'b1; clr_lo = 1'b1; step(); clr_hi = 1'b0; clr_lo = 1'b0;
      end
    end

    // Clear on a quiet cycle, then on an overflow cycle.
    run_hi = 1'b1;
    rld_data = 8'hFE; we_lo = 1'b1; step(); we_lo = 1'b0;
    for (int w = 0; w < 300 && !(cnt_lo == 8'hFE && flag_lo); w++) step();
    chk(cnt_lo == 8'hFE && flag_lo, "R6 short period reached", cnt_lo, 8'hFE);
    clr_lo = 1'b1; step(); clr_lo = 1'b0;
    chk(flag_lo === 1'b0, "R8 clear without overflow", flag_lo, 0);
    chk(cnt_lo === 8'hFF, "R1 count at top", cnt_lo, 8'hFF);
    clr_lo = 1'b1; step(); clr_lo = 1'b0;
    chk(flag_lo === 1'b1, "R9 set wins over clear", flag_lo, 1);
    chk(cnt_lo === 8'hFE, "R6 reload not zero", cnt_lo, 8'hFE);

    // Divided system clock.
    track = 1'b0;
    do_reset();
    run_hi = 1'b1;
    spacing(12, "R4 div12 gap", 6);

    // Divided external clock.
    do_reset();
    run_hi = 1'b1; ext_sel = 1'b1; ext_on = 1'b1;
    spacing(64, "R5 ext/8 gap", 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule